// File: doc/BRIEF.md
# Narrow-to-Wide Register Access Bridge

This block lets a host that issues only 32-bit register accesses reach a bank of 64-bit internal registers. The host first stages a 64-bit value in two 32-bit windows, the upper window holding the high half and the lower window holding the low half. It then writes a command word. Bit 31 of that word selects the direction, and its low bits pick a register index. The bridge adds a fixed base to the index to form the internal address and runs exactly one 64-bit transaction on a valid/ready request port. It waits for the matching response, and a read response then fills the two windows. A status word shows whether the bridge is still busy and whether any access has failed.

Errors are sticky. Two things set the summary error bit: an index outside the mapped range, which is refused without any internal request, and an error flag on a response. The bit stays set until the host writes the clear register. An enable register turns this error bit into a level interrupt. While a transaction is in flight, the bridge ignores host writes to the command and data windows. The staged value and the issued request therefore cannot change under a running access.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset the high window, low window, command readback, status word and interrupt enable all read as zero, `irq` is low and `req_valid` is low.
- R2: Host byte offsets are: high window 0x00, low window 0x04, command 0x08, clear 0x18, status 0x1c, interrupt enable 0x20. Any other offset reads as zero. A command write with bit 31 set issues one request with `req_write`=1, `req_wdata` = {high window, low window} and `req_addr` = BASE + command[IDX_W-1:0].
- R3: A command write with bit 31 clear issues one read request. When its response comes back without error, the high window takes `rsp_rdata[63:32]` and the low window takes `rsp_rdata[31:0]`.
- R4: A completed write access leaves both data windows unchanged.
- R5: Once `req_valid` is high it stays high, with address, write flag and data stable, until the cycle in which `req_ready` is high.
- R6: Status bit 0 (busy) is 1 from the cycle after an accepted command write until the response is taken. While busy, host writes to the command and data windows have no effect, and the command readback keeps the accepted command.
- R7: A command whose index is REG_COUNT or above issues no request, leaves busy at 0, and sets status bit 31.
- R8: A response with `rsp_err` high sets status bit 31. If it answers a read, the data windows keep their previous values.
- R9: Status bit 31 stays set across later commands until a host write of any value to the clear register, after which it reads 0.
- R10: Bit 0 of the interrupt enable register reads back as written, and `irq` is high exactly when that bit and status bit 31 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | HOST_AW | Host byte offset for reads and writes |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from host_addr |
| irq | output | 1 | Level interrupt: error flag and enable |
| req_valid | output | 1 | Internal request valid |
| req_ready | input | 1 | Internal request accepted |
| req_addr | output | INT_AW | Internal register address |
| req_write | output | 1 | 1 = write, 0 = read |
| req_wdata | output | 64 | Internal write data |
| rsp_valid | input | 1 | Internal response valid |
| rsp_rdata | input | 64 | Internal read data |
| rsp_err | input | 1 | Internal error flag |

## Verification
The bench sweeps every mapped index with a write and a read-back, using values built arithmetically from the index. A bridge that swapped the halves would show high and low words exchanged, and an address built without the base would land in the wrong slot of the bench's target model. It also sweeps every unmapped index. A wrong range compare would either reach the target, which the bench's request count catches, or miss the error bit. With the target stalled, the bench issues a second command and a data write. A bridge that did not hold them off would issue a second request or corrupt the staged value. Errored read responses, error stickiness and the clear write are checked as well. So is the interrupt gating, where a bridge that let writes overwrite the windows or cleared the error early would show the wrong readback.

// File: rtl/wide_reg_bridge_pkg.sv
package wide_reg_bridge_pkg;

   // Host-visible byte offsets (fixed map decoded by host software)
   localparam logic [7:0] OFF_DATA_HI = 8'h00;
   localparam logic [7:0] OFF_DATA_LO = 8'h04;
   localparam logic [7:0] OFF_CMD     = 8'h08;
   localparam logic [7:0] OFF_CLEAR   = 8'h18;
   localparam logic [7:0] OFF_STATUS  = 8'h1c;
   localparam logic [7:0] OFF_IRQ_EN  = 8'h20;

   localparam int CMD_DIR_BIT    = 31;
   localparam int STAT_ERR_BIT   = 31;
   localparam int STAT_BUSY_BIT  = 0;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_REQ  = 2'd1,
      SQ_WAIT = 2'd2
   } seq_state_t;

endpackage

// File: rtl/wide_reg_bridge_host.sv
module wide_reg_bridge_host
   import wide_reg_bridge_pkg::*;
#(
   parameter int HOST_AW = 8,
   parameter int IDX_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_wr,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [31:0]        host_wdata,
   output logic [31:0]        host_rdata,
   input  logic               busy_i,
   input  logic               rd_done_i,
   input  logic [63:0]        rd_data_i,
   input  logic               err_set_i,
   output logic               cmd_fire_o,
   output logic               cmd_write_o,
   output logic [IDX_W-1:0]   cmd_idx_o,
   output logic [63:0]        stage_o,
   output logic               irq_o
);

   localparam logic [HOST_AW-1:0] A_HI     = HOST_AW'(OFF_DATA_HI);
   localparam logic [HOST_AW-1:0] A_LO     = HOST_AW'(OFF_DATA_LO);
   localparam logic [HOST_AW-1:0] A_CMD    = HOST_AW'(OFF_CMD);
   localparam logic [HOST_AW-1:0] A_CLEAR  = HOST_AW'(OFF_CLEAR);
   localparam logic [HOST_AW-1:0] A_STATUS = HOST_AW'(OFF_STATUS);
   localparam logic [HOST_AW-1:0] A_IRQ    = HOST_AW'(OFF_IRQ_EN);

   logic [31:0] hi_q, lo_q, cmd_q;
   logic        err_q, irq_en_q;
   logic        wr_hi, wr_lo, wr_cmd, wr_clear, wr_irq;

   always_comb begin
      wr_hi    = host_wr && (host_addr == A_HI)    && !busy_i;
      wr_lo    = host_wr && (host_addr == A_LO)    && !busy_i;
      wr_cmd   = host_wr && (host_addr == A_CMD)   && !busy_i;
      wr_clear = host_wr && (host_addr == A_CLEAR);
      wr_irq   = host_wr && (host_addr == A_IRQ);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q     <= '0;
         lo_q     <= '0;
         cmd_q    <= '0;
         err_q    <= 1'b0;
         irq_en_q <= 1'b0;
      end else begin
         if (rd_done_i) begin
            hi_q <= rd_data_i[63:32];
            lo_q <= rd_data_i[31:0];
         end else begin
            if (wr_hi) hi_q <= host_wdata;
            if (wr_lo) lo_q <= host_wdata;
         end
         if (wr_cmd) cmd_q <= host_wdata;
         if (err_set_i)     err_q <= 1'b1;
         else if (wr_clear) err_q <= 1'b0;
         if (wr_irq) irq_en_q <= host_wdata[0];
      end
   end

   always_comb begin
      host_rdata = '0;
      if (host_addr == A_HI)          host_rdata = hi_q;
      else if (host_addr == A_LO)     host_rdata = lo_q;
      else if (host_addr == A_CMD)    host_rdata = cmd_q;
      else if (host_addr == A_STATUS) begin
         host_rdata[STAT_ERR_BIT]  = err_q;
         host_rdata[STAT_BUSY_BIT] = busy_i;
      end
      else if (host_addr == A_IRQ)    host_rdata = {31'b0, irq_en_q};
   end

   assign cmd_fire_o  = wr_cmd;
   assign cmd_write_o = host_wdata[CMD_DIR_BIT];
   assign cmd_idx_o   = host_wdata[IDX_W-1:0];
   assign stage_o     = {hi_q, lo_q};
   assign irq_o       = err_q && irq_en_q;

   // R9
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q && !(host_wr && host_addr == A_CLEAR) |=> err_q);

   // R4
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_done_i && !(host_wr && !busy_i) |=> $stable(hi_q) && $stable(lo_q));

   // R6
   busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> $stable(cmd_q));

endmodule

// File: rtl/wide_reg_bridge_seq.sv
module wide_reg_bridge_seq
   import wide_reg_bridge_pkg::*;
#(
   parameter int          IDX_W     = 4,
   parameter int          REG_COUNT = 8,
   parameter int          INT_AW    = 8,
   parameter int unsigned BASE      = 32'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_fire_i,
   input  logic              cmd_write_i,
   input  logic [IDX_W-1:0]  cmd_idx_i,
   input  logic [63:0]       stage_i,
   output logic              busy_o,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [INT_AW-1:0] req_addr,
   output logic              req_write,
   output logic [63:0]       req_wdata,
   input  logic              rsp_valid,
   input  logic [63:0]       rsp_rdata,
   input  logic              rsp_err,
   output logic              rd_done_o,
   output logic [63:0]       rd_data_o,
   output logic              err_set_o
);

   localparam int FULL_MAP = (REG_COUNT == (1 << IDX_W)) ? 1 : 0;
   localparam logic [INT_AW-1:0] BASE_A = INT_AW'(BASE);
   localparam logic [INT_AW-1:0] LIMIT_A = INT_AW'(BASE + REG_COUNT);

   seq_state_t state_q;
   logic       unmapped;
   logic       launch;
   logic       rsp_take;

   generate
      if (FULL_MAP != 0) begin : g_full_map
         assign unmapped = 1'b0;
      end else begin : g_partial_map
         assign unmapped = (32'(cmd_idx_i) >= 32'(REG_COUNT));
      end
   endgenerate

   assign launch   = cmd_fire_i && !unmapped;
   assign rsp_take = (state_q == SQ_WAIT) && rsp_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= SQ_IDLE;
         req_addr  <= '0;
         req_write <= 1'b0;
         req_wdata <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: if (launch) begin
               state_q   <= SQ_REQ;
               req_addr  <= BASE_A + INT_AW'(cmd_idx_i);
               req_write <= cmd_write_i;
               req_wdata <= stage_i;
            end
            SQ_REQ:  if (req_ready) state_q <= SQ_WAIT;
            SQ_WAIT: if (rsp_valid) state_q <= SQ_IDLE;
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign req_valid = (state_q == SQ_REQ);
   assign busy_o    = (state_q != SQ_IDLE);
   assign rd_done_o = rsp_take && !rsp_err && !req_write;
   assign rd_data_o = rsp_rdata;
   assign err_set_o = (cmd_fire_i && unmapped) || (rsp_take && rsp_err);

   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_addr)
                                  && $stable(req_write) && $stable(req_wdata));

   // R7
   req_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_addr >= BASE_A) && (req_addr < LIMIT_A));

   // R6
   req_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) |-> $past(cmd_fire_i));

endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
   import wide_reg_bridge_pkg::*;
#(
   parameter int          HOST_AW   = 8,
   parameter int          IDX_W     = 4,
   parameter int          REG_COUNT = 8,
   parameter int          INT_AW    = 8,
   parameter int unsigned BASE      = 32'h20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_wr,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [31:0]        host_wdata,
   output logic [31:0]        host_rdata,
   output logic               irq,
   output logic               req_valid,
   input  logic               req_ready,
   output logic [INT_AW-1:0]  req_addr,
   output logic               req_write,
   output logic [63:0]        req_wdata,
   input  logic               rsp_valid,
   input  logic [63:0]       rsp_rdata,
   input  logic               rsp_err
);

   generate
      if (HOST_AW < 6 || HOST_AW > 16) begin : g_bad_host_aw
         $error("HOST_AW must lie in 6..16 to decode the map");
      end
      if (IDX_W < 1 || IDX_W > 30) begin : g_bad_idx_w
         $error("IDX_W must lie in 1..30");
      end
      if (REG_COUNT < 1 || REG_COUNT > (1 << IDX_W)) begin : g_bad_count
         $error("REG_COUNT must lie in 1..2**IDX_W");
      end
      if (INT_AW < 1 || INT_AW > 31 || (BASE + REG_COUNT) > (32'd1 << INT_AW)) begin : g_bad_base
         $error("BASE + REG_COUNT must fit in INT_AW bits");
      end
   endgenerate

   logic              busy;
   logic              rd_done;
   logic [63:0]       rd_data;
   logic              err_set;
   logic              cmd_fire;
   logic              cmd_write;
   logic [IDX_W-1:0]  cmd_idx;
   logic [63:0]       stage;

   wide_reg_bridge_host #(
      .HOST_AW (HOST_AW),
      .IDX_W   (IDX_W)
   ) i_host (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_wr     (host_wr),
      .host_addr   (host_addr),
      .host_wdata  (host_wdata),
      .host_rdata  (host_rdata),
      .busy_i      (busy),
      .rd_done_i   (rd_done),
      .rd_data_i   (rd_data),
      .err_set_i   (err_set),
      .cmd_fire_o  (cmd_fire),
      .cmd_write_o (cmd_write),
      .cmd_idx_o   (cmd_idx),
      .stage_o     (stage),
      .irq_o       (irq)
   );

   wide_reg_bridge_seq #(
      .IDX_W     (IDX_W),
      .REG_COUNT (REG_COUNT),
      .INT_AW    (INT_AW),
      .BASE      (BASE)
   ) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_fire_i  (cmd_fire),
      .cmd_write_i (cmd_write),
      .cmd_idx_i   (cmd_idx),
      .stage_i     (stage),
      .busy_o      (busy),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_addr    (req_addr),
      .req_write   (req_write),
      .req_wdata   (req_wdata),
      .rsp_valid   (rsp_valid),
      .rsp_rdata   (rsp_rdata),
      .rsp_err     (rsp_err),
      .rd_done_o   (rd_done),
      .rd_data_o   (rd_data),
      .err_set_o   (err_set)
   );

   // R10
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !busy || $stable(irq) || $past(err_set) || $past(host_wr));

endmodule

// File: tb/test_wide_reg_bridge.sv
`timescale 1ns/1ps
module test_wide_reg_bridge;

   localparam int HAW = 8;
   localparam int IW  = 4;
   localparam int RC  = 8;
   localparam int IAW = 8;
   localparam int unsigned BASE = 32'h20;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           host_wr = 1'b0;
   logic [HAW-1:0] host_addr = '0;
   logic [31:0]    host_wdata = '0;
   logic [31:0]    host_rdata;
   logic           irq;
   logic           req_valid;
   logic           req_ready = 1'b0;
   logic [IAW-1:0] req_addr;
   logic           req_write;
   logic [63:0]    req_wdata;
   logic           rsp_valid = 1'b0;
   logic [63:0]    rsp_rdata = '0;
   logic           rsp_err = 1'b0;

   int tests = 0;
   int fails = 0;
   int reqs  = 0;
   int stall = 0;
   logic inject_err = 1'b0;
   logic [63:0] tmem [RC];

   always #2.5 clk = ~clk;

   wide_reg_bridge #(.HOST_AW(HAW), .IDX_W(IW), .REG_COUNT(RC), .INT_AW(IAW), .BASE(BASE))
   i_wide_reg_bridge (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_write(req_write), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
   );

   // Target model: acts at falling edges only
   initial begin
      int phase;
      int waited;
      int slot;
      logic [IAW-1:0] a_q;
      logic w_q;
      logic [63:0] d_q;
      phase = 0; waited = 0;
      a_q = '0; w_q = 1'b0; d_q = '0;
      forever begin
         @(negedge clk);
         if (phase == 0) begin
            rsp_valid = 1'b0;
            if (req_valid && rst_n) begin
               if (waited < stall) begin
                  waited++;
                  req_ready = 1'b0;
               end else begin
                  req_ready = 1'b1;
                  a_q = req_addr; w_q = req_write; d_q = req_wdata;
                  reqs++;
                  phase = 1;
               end
            end
         end else begin
            req_ready = 1'b0;
            waited = 0;
            slot = int'(a_q) - int'(BASE);
            rsp_err = inject_err;
            rsp_rdata = 64'hDEAD_BEEF_0BAD_F00D;
            if (slot >= 0 && slot < RC) begin
               if (w_q) begin
                  if (!inject_err) tmem[slot] = d_q;
               end else rsp_rdata = tmem[slot];
            end
            rsp_valid = 1'b1;
            phase = 0;
         end
      end
   end

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hread(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int k = 0; k < 200; k++) begin
         hread(8'h1c, s);
         if (s[0] == 1'b0) break;
      end
   endtask

   function automatic logic [63:0] pat(input int i, input int salt);
      logic [31:0] h, l;
      h = 32'hA500_0000 + 32'(i) * 32'h0001_0101 + 32'(salt);
      l = 32'h0F0F_0F0F ^ (32'(i + salt) * 32'h0101_0101);
      return {h, l};
   endfunction

   initial begin
      int wd;
      wd = 0;
      while (wd < 150000) begin
         @(posedge clk);
         wd++;
      end
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", wd);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] r, h, l;
      logic [63:0] e;
      int n0;
      for (int i = 0; i < RC; i++) tmem[i] = 64'h0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      hread(8'h00, r); chk("R1 hi", r, 0);
      hread(8'h04, r); chk("R1 lo", r, 0);
      hread(8'h08, r); chk("R1 cmd", r, 0);
      hread(8'h1c, r); chk("R1 status", r, 0);
      hread(8'h20, r); chk("R1 irq_en", r, 0);
      chk("R1 irq pin", irq, 0);
      chk("R1 req_valid", req_valid, 0);
      // R2 unmapped offset reads zero
      hread(8'h0c, r); chk("R2 hole", r, 0);

      // R2 write sweep over every mapped index
      for (int i = 0; i < RC; i++) begin
         e = pat(i, 0);
         stall = i % 3;
         hwrite(8'h00, e[63:32]);
         hwrite(8'h04, e[31:0]);
         hwrite(8'h08, 32'h8000_0000 | 32'(i));
         wait_idle();
         chk("R2 target", tmem[i], e);
         // R4 windows unchanged by write
         hread(8'h00, r); chk("R4 hi", r, e[63:32]);
         hread(8'h04, r); chk("R4 lo", r, e[31:0]);
      end

      // R3 read-back sweep (clobber windows first)
      for (int i = RC - 1; i >= 0; i--) begin
         hwrite(8'h00, 32'h1111_1111);
         hwrite(8'h04, 32'h2222_2222);
         stall = (i * 2) % 5;
         hwrite(8'h08, 32'(i));
         wait_idle();
         e = pat(i, 0);
         hread(8'h00, h); chk("R3 hi", h, e[63:32]);
         hread(8'h04, l); chk("R3 lo", l, e[31:0]);
      end
      hread(8'h1c, r); chk("R3 status clean", r, 0);

      // R7 unmapped sweep
      for (int i = RC; i < (1 << IW); i++) begin
         n0 = reqs;
         hwrite(8'h08, 32'h8000_0000 | 32'(i));
         hread(8'h1c, r);
         chk("R7 status", r, 32'h8000_0000);
         repeat (3) @(negedge clk);
         chk("R7 no request", 64'(reqs), 64'(n0));
         hwrite(8'h18, 32'h0);
         hread(8'h1c, r); chk("R9 cleared", r, 0);
      end

      // R6 busy and ignored writes
      stall = 6;
      e = pat(2, 7);
      hwrite(8'h00, e[63:32]);
      hwrite(8'h04, e[31:0]);
      n0 = reqs;
      hwrite(8'h08, 32'h8000_0002);
      hread(8'h1c, r); chk("R6 busy", r, 32'h1);
      hwrite(8'h00, 32'hCCCC_CCCC);
      hwrite(8'h08, 32'h8000_0003);
      wait_idle();
      repeat (3) @(negedge clk);
      chk("R6 one request", 64'(reqs), 64'(n0 + 1));
      chk("R6 target2", tmem[2], e);
      chk("R6 target3 untouched", tmem[3], pat(3, 0));
      hread(8'h00, r); chk("R6 hi kept", r, e[63:32]);
      hread(8'h08, r); chk("R6 cmd kept", r, 32'h8000_0002);
      stall = 0;

      // R10 enable readback, irq low without error
      hwrite(8'h20, 32'h1);
      hread(8'h20, r); chk("R10 enable", r, 1);
      chk("R10 irq idle", irq, 0);

      // R8 errored read keeps windows
      inject_err = 1'b1;
      hwrite(8'h08, 32'h0000_0005);
      wait_idle();
      inject_err = 1'b0;
      hread(8'h1c, r); chk("R8 status", r, 32'h8000_0000);
      hread(8'h00, r); chk("R8 hi kept", r, e[63:32]);
      hread(8'h04, r); chk("R8 lo kept", r, e[31:0]);
      chk("R10 irq set", irq, 1);

      // R9 sticky across a good command
      hwrite(8'h08, 32'h0000_0004);
      wait_idle();
      hread(8'h1c, r); chk("R9 sticky", r, 32'h8000_0000);
      e = pat(4, 0);
      hread(8'h00, r); chk("R3 after err", r, e[63:32]);
      hwrite(8'h18, 32'hFFFF_FFFF);
      hread(8'h1c, r); chk("R9 clear", r, 0);
      chk("R10 irq cleared", irq, 0);

      // R10 error with enable off
      hwrite(8'h20, 32'h0);
      hwrite(8'h08, 32'h0000_000F);
      hread(8'h1c, r); chk("R7 err again", r, 32'h8000_0000);
      chk("R10 irq masked", irq, 0);

      // R8 errored write leaves target untouched
      inject_err = 1'b1;
      hwrite(8'h08, 32'h8000_0001);
      wait_idle();
      inject_err = 1'b0;
      chk("R8 write err target", tmem[1], pat(1, 0));

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule